// File: doc/BRIEF.md
# Rectangle Blit Address Engine

The engine carries out two drawing operations on a byte-addressed linear framebuffer held in a synchronous RAM. A solid fill paints a rectangle with a colour word. A block copy moves a rectangle from a source origin to a destination origin. Every command gives the rectangle origin, width and height, the number of bytes in each pixel, the byte distance between scanlines, and the current surface dimensions. A copy also gives a source origin and a fill also gives a colour.

The engine first checks every rectangle it will touch against fixed maximum coordinates and against the surface size. A command that fails the check is retired at once with a rejected status, and the engine makes no memory access for it. An accepted command is turned into a stream of byte reads and writes, one scanline at a time. For a copy, the engine picks the traversal direction so that a source overlapping its destination is read before it is overwritten. When the drawing is finished, the destination rectangle is offered on a valid/ready port as a dirty region so that the display path can refresh it. A single-cycle done pulse with a status bit then closes the command.

Top module: `blit_rect_engine`

## Requirements
- R1: A command is rejected (done with done_ok=0, no memory write, no dirty region) when the bytes-per-pixel input is 0 or above 4, or when a checked rectangle has x<0, y<0, w<0, h<0, x>2368, w>2368, y>1770, h>1770, x+w>surf_w or y+h>surf_h. The limits are inclusive, so x+w=surf_w is accepted.
- R2: cmd_op=1 selects copy and cmd_op=0 selects fill. A copy is accepted only when both the source and the destination rectangles pass R1. A fill checks only the destination.
- R3: Pixel (x,y) starts at byte address pix_bytes*x + line_stride*y, taken modulo 2^ADDR_W. Each row spans pix_bytes*w bytes. An accepted command writes exactly pix_bytes*w*h bytes, and only inside its destination rows.
- R4: A fill writes colour byte (k mod pix_bytes) to byte k of every destination row. Colour byte 0 is fill_colour[7:0], byte 1 is fill_colour[15:8], and so on.
- R5: After a copy, every destination byte holds the value its source byte had before the command, even when the two rectangles overlap.
- R6: A copy runs backward when the destination starts after the source (dst_y>src_y, or dst_y=src_y and dst_x>src_x). A backward copy starts from the last byte of the last row, so its first write goes to the last byte of destination row h-1. Every other command writes the first byte of row 0 first.
- R7: After an accepted command, dirty_valid rises with dirty_x/y/w/h equal to the destination rectangle. These outputs hold steady until dirty_ready is seen, and the next cycle brings done with done_ok=1.
- R8: done is a one-cycle pulse. cmd_ready is high only while the engine is idle, and a command is taken when cmd_valid and cmd_ready are both high. After reset the engine is idle with done, dirty_valid and both memory enables low.
- R9: A command with w=0 or h=0 that passes R1 writes nothing but still presents its dirty region and completes with done_ok=1.
- R10: Memory reads return data one cycle after mem_rd_en. The engine never reads and writes in the same cycle, and each copy read is followed in the next cycle by its write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command will be taken |
| cmd_op | input | 1 | 0 fill, 1 copy |
| src_x | input | COORD_W | Copy source x (signed) |
| src_y | input | COORD_W | Copy source y (signed) |
| dst_x | input | COORD_W | Destination x (signed) |
| dst_y | input | COORD_W | Destination y (signed) |
| rect_w | input | COORD_W | Width in pixels (signed) |
| rect_h | input | COORD_W | Height in rows (signed) |
| fill_colour | input | 8*MAX_BPP | Fill colour word |
| pix_bytes | input | BPP_W | Bytes per pixel |
| line_stride | input | STRIDE_W | Bytes between scanlines |
| surf_w | input | COORD_W | Surface width in pixels |
| surf_h | input | COORD_W | Surface height in rows |
| mem_rd_en | output | 1 | Byte read request |
| mem_rd_addr | output | ADDR_W | Read address |
| mem_rd_data | input | 8 | Read data, one cycle after the request |
| mem_wr_en | output | 1 | Byte write strobe |
| mem_wr_addr | output | ADDR_W | Write address |
| mem_wr_data | output | 8 | Write data |
| dirty_valid | output | 1 | Dirty region offered |
| dirty_ready | input | 1 | Dirty region taken |
| dirty_x | output | COORD_W | Dirty region x |
| dirty_y | output | COORD_W | Dirty region y |
| dirty_w | output | COORD_W | Dirty region width |
| dirty_h | output | COORD_W | Dirty region height |
| done | output | 1 | Command finished (one cycle) |
| done_ok | output | 1 | Status with done: 1 drawn, 0 rejected |

## Verification
The assertions assume a RAM that returns read data in the cycle after mem_rd_en. They also assume that the line stride is at least pix_bytes times the surface width, so scanlines never overlap in memory and the coordinate comparison in R6 matches the address order. The bench's memory model has exactly that one-cycle latency. Every drawing case uses a 16x8 surface with a stride of 16*pix_bytes+4, which keeps each accepted rectangle inside separate rows of the modelled RAM. Commands on the large surface that probe the hard limits have zero area, so the address wrap never comes into play.

// File: rtl/blit_pkg.sv
package blit_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CHECK,
      ST_FILL,
      ST_RD,
      ST_WR,
      ST_DIRTY,
      ST_DONE
   } blit_state_e;

   localparam logic OP_FILL = 1'b0;
   localparam logic OP_COPY = 1'b1;
endpackage

// File: rtl/blit_rect_check.sv
// Combinational validation of one rectangle against hard limits and surface.
module blit_rect_check #(
   parameter int COORD_W = 13,
   parameter int MAX_W   = 2368,
   parameter int MAX_H   = 1770
) (
   input  logic signed [COORD_W-1:0] x,
   input  logic signed [COORD_W-1:0] y,
   input  logic signed [COORD_W-1:0] w,
   input  logic signed [COORD_W-1:0] h,
   input  logic        [COORD_W-1:0] surf_w,
   input  logic        [COORD_W-1:0] surf_h,
   output logic                      ok
);
   localparam int EW = COORD_W + 1;
   localparam logic signed [EW-1:0] LIM_W = EW'(MAX_W);
   localparam logic signed [EW-1:0] LIM_H = EW'(MAX_H);

   logic signed [EW-1:0] xe, ye, we, he, swe, she, right_e, bottom_e;
   logic x_bad, y_bad;

   assign xe       = EW'(x);
   assign ye       = EW'(y);
   assign we       = EW'(w);
   assign he       = EW'(h);
   assign swe      = $signed({1'b0, surf_w});
   assign she      = $signed({1'b0, surf_h});
   assign right_e  = xe + we;
   assign bottom_e = ye + he;

   assign x_bad = xe[EW-1] || we[EW-1] || (xe > LIM_W) || (we > LIM_W) || (right_e > swe);
   assign y_bad = ye[EW-1] || he[EW-1] || (ye > LIM_H) || (he > LIM_H) || (bottom_e > she);
   assign ok    = !x_bad && !y_bad;
endmodule

// File: rtl/blit_line_base.sv
// Byte address of the first pixel of a row segment.
module blit_line_base #(
   parameter int COORD_W  = 13,
   parameter int ADDR_W   = 24,
   parameter int BPP_W    = 3,
   parameter int STRIDE_W = 16
) (
   input  logic [COORD_W-1:0]  x,
   input  logic [COORD_W-1:0]  y,
   input  logic [BPP_W-1:0]    bpp,
   input  logic [STRIDE_W-1:0] stride,
   output logic [ADDR_W-1:0]   addr
);
   assign addr = ADDR_W'(bpp) * ADDR_W'(x) + ADDR_W'(stride) * ADDR_W'(y);
endmodule

// File: rtl/blit_fill_byte.sv
// Selects the colour byte for the current position inside a pixel.
module blit_fill_byte #(
   parameter int MAX_BPP = 4,
   parameter int PH_W    = 2
) (
   input  logic [8*MAX_BPP-1:0] colour,
   input  logic [PH_W-1:0]      phase,
   output logic [7:0]           byte_o
);
   generate
      if ((MAX_BPP & (MAX_BPP - 1)) == 0 && MAX_BPP > 1) begin : g_pow2
         assign byte_o = colour[{phase, 3'b000} +: 8];
      end else begin : g_mux
         always_comb begin
            byte_o = colour[7:0];
            for (int i = 1; i < MAX_BPP; i++) begin
               if (phase == PH_W'(i)) byte_o = colour[8*i +: 8];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/blit_rect_engine.sv
module blit_rect_engine
   import blit_pkg::*;
#(
   parameter int COORD_W  = 13,
   parameter int MAX_W    = 2368,
   parameter int MAX_H    = 1770,
   parameter int ADDR_W   = 24,
   parameter int STRIDE_W = 16,
   parameter int MAX_BPP  = 4,
   parameter int BPP_W    = $clog2(MAX_BPP + 1),
   parameter int COLOUR_W = 8 * MAX_BPP
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cmd_valid,
   output logic                      cmd_ready,
   input  logic                      cmd_op,
   input  logic signed [COORD_W-1:0] src_x,
   input  logic signed [COORD_W-1:0] src_y,
   input  logic signed [COORD_W-1:0] dst_x,
   input  logic signed [COORD_W-1:0] dst_y,
   input  logic signed [COORD_W-1:0] rect_w,
   input  logic signed [COORD_W-1:0] rect_h,
   input  logic [COLOUR_W-1:0]       fill_colour,
   input  logic [BPP_W-1:0]          pix_bytes,
   input  logic [STRIDE_W-1:0]       line_stride,
   input  logic [COORD_W-1:0]        surf_w,
   input  logic [COORD_W-1:0]        surf_h,
   output logic                      mem_rd_en,
   output logic [ADDR_W-1:0]         mem_rd_addr,
   input  logic [7:0]                mem_rd_data,
   output logic                      mem_wr_en,
   output logic [ADDR_W-1:0]         mem_wr_addr,
   output logic [7:0]                mem_wr_data,
   output logic                      dirty_valid,
   input  logic                      dirty_ready,
   output logic [COORD_W-1:0]        dirty_x,
   output logic [COORD_W-1:0]        dirty_y,
   output logic [COORD_W-1:0]        dirty_w,
   output logic [COORD_W-1:0]        dirty_h,
   output logic                      done,
   output logic                      done_ok
);
   localparam int LINE_W = COORD_W + BPP_W;
   localparam int PH_W   = (MAX_BPP > 1) ? $clog2(MAX_BPP) : 1;
   localparam int N_RECT = 2;   // index 0 source, index 1 destination

   generate
      if (MAX_BPP < 1) begin : g_bad_bpp
         $error("MAX_BPP must be at least 1");
      end
      if (MAX_W >= (1 << (COORD_W - 1)) || MAX_H >= (1 << (COORD_W - 1))) begin : g_bad_coord
         $error("COORD_W too narrow for the coordinate limits");
      end
      if (COLOUR_W != 8 * MAX_BPP) begin : g_bad_colour
         $error("COLOUR_W must be 8*MAX_BPP");
      end
   endgenerate

   blit_state_e state;

   // latched command
   logic                      op_q;
   logic signed [COORD_W-1:0] sx_q, sy_q, dx_q, dy_q, w_q, h_q;
   logic [COLOUR_W-1:0]       col_q;
   logic [BPP_W-1:0]          bpp_q;
   logic [STRIDE_W-1:0]       stride_q;
   logic [COORD_W-1:0]        sw_q, sh_q;

   // run state
   logic                      ok_q, rev_q;
   logic [ADDR_W-1:0]         src_line, dst_line, src_ptr, dst_ptr;
   logic [LINE_W-1:0]         nbytes_q, col_left;
   logic [COORD_W-1:0]        row_left;
   logic [PH_W-1:0]           phase_q;

   // validation and base address per rectangle
   logic signed [COORD_W-1:0] rx [N_RECT];
   logic signed [COORD_W-1:0] ry [N_RECT];
   logic signed [COORD_W-1:0] ys [N_RECT];
   logic                      rok [N_RECT];
   logic [ADDR_W-1:0]         base_c [N_RECT];
   logic                      rev_c, bpp_ok, valid_c;
   logic [LINE_W-1:0]         nbytes_c;
   logic [ADDR_W-1:0]         span_c;

   assign rx[0] = sx_q;
   assign ry[0] = sy_q;
   assign rx[1] = dx_q;
   assign ry[1] = dy_q;

   assign rev_c = (op_q == OP_COPY) &&
                  ((dy_q > sy_q) || ((dy_q == sy_q) && (dx_q > sx_q)));

   generate
      for (genvar g = 0; g < N_RECT; g++) begin : g_rect
         assign ys[g] = rev_c ? (ry[g] + (h_q - COORD_W'(1))) : ry[g];

         blit_rect_check #(
            .COORD_W(COORD_W), .MAX_W(MAX_W), .MAX_H(MAX_H)
         ) u_check (
            .x(rx[g]), .y(ry[g]), .w(w_q), .h(h_q),
            .surf_w(sw_q), .surf_h(sh_q), .ok(rok[g])
         );

         blit_line_base #(
            .COORD_W(COORD_W), .ADDR_W(ADDR_W), .BPP_W(BPP_W), .STRIDE_W(STRIDE_W)
         ) u_base (
            .x($unsigned(rx[g])), .y($unsigned(ys[g])),
            .bpp(bpp_q), .stride(stride_q), .addr(base_c[g])
         );
      end
   endgenerate

   assign bpp_ok   = (bpp_q != '0) && (bpp_q <= BPP_W'(MAX_BPP));
   assign valid_c  = bpp_ok && rok[1] && ((op_q == OP_FILL) || rok[0]);
   assign nbytes_c = LINE_W'(bpp_q) * LINE_W'($unsigned(w_q));
   assign span_c   = ADDR_W'(nbytes_c - LINE_W'(1));

   // per-byte stepping
   logic              last_col, last_row, adv;
   logic [ADDR_W-1:0] stride_a, nspan_a, nx_src_line, nx_dst_line, nx_src_ptr, nx_dst_ptr;
   logic [PH_W-1:0]   nx_phase;

   assign last_col = (col_left == LINE_W'(1));
   assign last_row = (row_left == COORD_W'(1));
   assign adv      = (state == ST_FILL) || (state == ST_WR);
   assign stride_a = ADDR_W'(stride_q);
   assign nspan_a  = ADDR_W'(nbytes_q - LINE_W'(1));

   always_comb begin
      nx_src_line = rev_q ? src_line - stride_a : src_line + stride_a;
      nx_dst_line = rev_q ? dst_line - stride_a : dst_line + stride_a;
      if (last_col) begin
         nx_src_ptr = rev_q ? nx_src_line + nspan_a : nx_src_line;
         nx_dst_ptr = rev_q ? nx_dst_line + nspan_a : nx_dst_line;
         nx_phase   = '0;
      end else begin
         nx_src_ptr = rev_q ? src_ptr - ADDR_W'(1) : src_ptr + ADDR_W'(1);
         nx_dst_ptr = rev_q ? dst_ptr - ADDR_W'(1) : dst_ptr + ADDR_W'(1);
         nx_phase   = (phase_q == PH_W'(bpp_q - BPP_W'(1))) ? '0 : phase_q + PH_W'(1);
      end
   end

   // control
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         ok_q  <= 1'b0;
      end else begin
         case (state)
            ST_IDLE:  if (cmd_valid) state <= ST_CHECK;
            ST_CHECK: begin
               ok_q <= valid_c;
               if (!valid_c)                    state <= ST_DONE;
               else if (w_q == '0 || h_q == '0) state <= ST_DIRTY;
               else if (op_q == OP_COPY)        state <= ST_RD;
               else                             state <= ST_FILL;
            end
            ST_FILL:  if (last_col && last_row) state <= ST_DIRTY;
            ST_RD:    state <= ST_WR;
            ST_WR:    state <= (last_col && last_row) ? ST_DIRTY : ST_RD;
            ST_DIRTY: if (dirty_ready) state <= ST_DONE;
            ST_DONE:  state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   // command capture
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q <= 1'b0; sx_q <= '0; sy_q <= '0; dx_q <= '0; dy_q <= '0;
         w_q <= '0; h_q <= '0; col_q <= '0; bpp_q <= '0; stride_q <= '0;
         sw_q <= '0; sh_q <= '0;
      end else if (state == ST_IDLE && cmd_valid) begin
         op_q <= cmd_op; sx_q <= src_x; sy_q <= src_y; dx_q <= dst_x; dy_q <= dst_y;
         w_q <= rect_w; h_q <= rect_h; col_q <= fill_colour; bpp_q <= pix_bytes;
         stride_q <= line_stride; sw_q <= surf_w; sh_q <= surf_h;
      end
   end

   // datapath
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rev_q <= 1'b0; src_line <= '0; dst_line <= '0; src_ptr <= '0; dst_ptr <= '0;
         nbytes_q <= '0; col_left <= '0; row_left <= '0; phase_q <= '0;
      end else if (state == ST_CHECK) begin
         rev_q    <= rev_c;
         nbytes_q <= nbytes_c;
         col_left <= nbytes_c;
         row_left <= $unsigned(h_q);
         phase_q  <= '0;
         src_line <= base_c[0];
         dst_line <= base_c[1];
         src_ptr  <= rev_c ? base_c[0] + span_c : base_c[0];
         dst_ptr  <= rev_c ? base_c[1] + span_c : base_c[1];
      end else if (adv) begin
         src_ptr  <= nx_src_ptr;
         dst_ptr  <= nx_dst_ptr;
         phase_q  <= nx_phase;
         if (last_col) begin
            col_left <= nbytes_q;
            row_left <= row_left - COORD_W'(1);
            src_line <= nx_src_line;
            dst_line <= nx_dst_line;
         end else begin
            col_left <= col_left - LINE_W'(1);
         end
      end
   end

   logic [7:0] fill_b;

   blit_fill_byte #(.MAX_BPP(MAX_BPP), .PH_W(PH_W)) u_fill (
      .colour(col_q), .phase(phase_q), .byte_o(fill_b)
   );

   assign cmd_ready   = (state == ST_IDLE);
   assign mem_rd_en   = (state == ST_RD);
   assign mem_rd_addr = src_ptr;
   assign mem_wr_en   = adv;
   assign mem_wr_addr = dst_ptr;
   assign mem_wr_data = (state == ST_WR) ? mem_rd_data : fill_b;
   assign dirty_valid = (state == ST_DIRTY);
   assign dirty_x     = $unsigned(dx_q);
   assign dirty_y     = $unsigned(dy_q);
   assign dirty_w     = $unsigned(w_q);
   assign dirty_h     = $unsigned(h_q);
   assign done        = (state == ST_DONE);
   assign done_ok     = ok_q;
endmodule

// File: rtl/blit_rect_engine_chk.sv
module blit_rect_engine_chk #(
   parameter int COORD_W = 13
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cmd_valid,
   input logic               cmd_ready,
   input logic               mem_rd_en,
   input logic               mem_wr_en,
   input logic               dirty_valid,
   input logic               dirty_ready,
   input logic [COORD_W-1:0] dirty_x,
   input logic [COORD_W-1:0] dirty_y,
   input logic [COORD_W-1:0] dirty_w,
   input logic [COORD_W-1:0] dirty_h,
   input logic               done,
   input logic               done_ok
);
   // R10
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_en && mem_wr_en));

   // R10
   rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> mem_wr_en);

   // R7
   dirty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dirty_valid && !dirty_ready) |=> (dirty_valid && $stable(dirty_x) &&
         $stable(dirty_y) && $stable(dirty_w) && $stable(dirty_h)));

   // R7
   dirty_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dirty_valid && dirty_ready) |=> (done && done_ok));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en || mem_wr_en || dirty_valid || done) |-> !cmd_ready);

   // R8
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> !cmd_ready);

   // R1
   reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !done_ok) |-> $past(!mem_wr_en && !mem_rd_en && !dirty_valid));
endmodule

bind blit_rect_engine blit_rect_engine_chk #(.COORD_W(COORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
   .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
   .dirty_valid(dirty_valid), .dirty_ready(dirty_ready),
   .dirty_x(dirty_x), .dirty_y(dirty_y), .dirty_w(dirty_w), .dirty_h(dirty_h),
   .done(done), .done_ok(done_ok)
);

// File: tb/blit_rect_engine_tb.sv
module blit_rect_engine_tb;
   localparam int CW = 13;
   localparam int AW = 12;
   localparam int MEMSZ = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic            cmd_valid = 1'b0, cmd_ready, cmd_op = 1'b0;
   logic signed [CW-1:0] src_x = '0, src_y = '0, dst_x = '0, dst_y = '0, rect_w = '0, rect_h = '0;
   logic [31:0]     fill_colour = '0;
   logic [2:0]      pix_bytes = 3'd1;
   logic [15:0]     line_stride = '0;
   logic [CW-1:0]   surf_w = '0, surf_h = '0;
   logic            mem_rd_en, mem_wr_en, dirty_valid, done, done_ok;
   logic            dirty_ready = 1'b0;
   logic [AW-1:0]   mem_rd_addr, mem_wr_addr;
   logic [7:0]      mem_rd_data = '0, mem_wr_data;
   logic [CW-1:0]   dirty_x, dirty_y, dirty_w, dirty_h;

   blit_rect_engine #(.COORD_W(CW), .ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .src_x(src_x), .src_y(src_y), .dst_x(dst_x), .dst_y(dst_y),
      .rect_w(rect_w), .rect_h(rect_h), .fill_colour(fill_colour),
      .pix_bytes(pix_bytes), .line_stride(line_stride), .surf_w(surf_w), .surf_h(surf_h),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
      .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .dirty_valid(dirty_valid), .dirty_ready(dirty_ready),
      .dirty_x(dirty_x), .dirty_y(dirty_y), .dirty_w(dirty_w), .dirty_h(dirty_h),
      .done(done), .done_ok(done_ok)
   );

   // memory model: one-cycle read latency
   logic [7:0] mem [MEMSZ];
   logic [7:0] ref_mem [MEMSZ];
   logic [7:0] snap [MEMSZ];
   int wr_cnt = 0;
   int first_wr = -1;

   always @(posedge clk) begin
      if (mem_wr_en) begin
         mem[mem_wr_addr] <= mem_wr_data;
         if (wr_cnt == 0) first_wr = int'(mem_wr_addr);
         wr_cnt = wr_cnt + 1;
      end
      if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
   end

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (cyc > 190000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog: run hung, got %0d cycles expected fewer than 190000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(input bit cond, input string req, input string what, input int act, input int exp);
      n_chk = n_chk + 1;
      if (!cond) begin
         n_fail = n_fail + 1;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic bit rect_ok(int x, int y, int w, int h, int sw, int sh);
      return !(x < 0 || y < 0 || w < 0 || h < 0 || x > 2368 || w > 2368 ||
               y > 1770 || h > 1770 || x + w > sw || y + h > sh);
   endfunction

   // command fields
   int t_op, t_sx, t_sy, t_dx, t_dy, t_w, t_h, t_bpp, t_stride, t_sw, t_sh;
   logic [31:0] t_col;

   task automatic set_cmd(input int op, input int sx, input int sy, input int dx, input int dy,
                          input int w, input int h, input int bpp, input int sw, input int sh);
      t_op = op; t_sx = sx; t_sy = sy; t_dx = dx; t_dy = dy; t_w = w; t_h = h;
      t_bpp = bpp; t_sw = sw; t_sh = sh;
      t_stride = 16 * bpp + 4;
   endtask

   task automatic run_case(input string req);
      bit ok_e, rev_e, got_done, got_ok;
      int stall, dcnt, dx_g, dy_g, dw_g, dh_g, mism, bad_at, exp_first, nb, t;
      ok_e = (t_bpp >= 1 && t_bpp <= 4) && rect_ok(t_dx, t_dy, t_w, t_h, t_sw, t_sh) &&
             (t_op == 0 || rect_ok(t_sx, t_sy, t_w, t_h, t_sw, t_sh));
      rev_e = (t_op == 1) && (t_dy > t_sy || (t_dy == t_sy && t_dx > t_sx));
      nb = t_bpp * t_w;
      for (int i = 0; i < MEMSZ; i++) begin
         mem[i] = 8'(i * 7 + 3);
         ref_mem[i] = 8'(i * 7 + 3);
         snap[i] = 8'(i * 7 + 3);
      end
      if (ok_e) begin
         for (int r = 0; r < t_h; r++) begin
            for (int k = 0; k < nb; k++) begin
               int da, sa;
               da = (t_bpp * t_dx + t_stride * (t_dy + r) + k) % MEMSZ;
               sa = (t_bpp * t_sx + t_stride * (t_sy + r) + k) % MEMSZ;
               if (t_op == 0) ref_mem[da] = t_col[8 * (k % t_bpp) +: 8];
               else           ref_mem[da] = snap[sa];
            end
         end
      end
      if (rev_e) exp_first = (t_bpp * t_dx + t_stride * (t_dy + t_h - 1) + nb - 1) % MEMSZ;
      else       exp_first = (t_bpp * t_dx + t_stride * t_dy) % MEMSZ;
      wr_cnt = 0; first_wr = -1;
      // issue
      @(negedge clk);
      t = 0;
      while (!cmd_ready && t < 100) begin @(negedge clk); t++; end
      cmd_op = t_op[0]; src_x = CW'(t_sx); src_y = CW'(t_sy); dst_x = CW'(t_dx); dst_y = CW'(t_dy);
      rect_w = CW'(t_w); rect_h = CW'(t_h); fill_colour = t_col; pix_bytes = 3'(t_bpp);
      line_stride = 16'(t_stride); surf_w = CW'(t_sw); surf_h = CW'(t_sh);
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      got_done = 0; got_ok = 0; stall = 0; dcnt = 0; dx_g = 0; dy_g = 0; dw_g = 0; dh_g = 0;
      for (t = 0; t < 20000; t++) begin
         if (done) begin got_done = 1; got_ok = done_ok; break; end
         if (dirty_valid) begin
            if (stall < 2) begin
               stall++;
               dirty_ready = 1'b0;
            end else begin
               dirty_ready = 1'b1;
               dcnt++;
               dx_g = int'(dirty_x); dy_g = int'(dirty_y); dw_g = int'(dirty_w); dh_g = int'(dirty_h);
            end
         end else begin
            dirty_ready = 1'b0;
         end
         @(negedge clk);
      end
      dirty_ready = 1'b0;
      chk(got_done == 1, req, "completion (timeout)", int'(got_done), 1);
      chk(got_ok == ok_e, req, "done_ok status", int'(got_ok), int'(ok_e));
      chk(wr_cnt == (ok_e ? nb * t_h : 0), {req, "/R3"}, "bytes written", wr_cnt, ok_e ? nb * t_h : 0);
      mism = 0; bad_at = -1;
      for (int i = 0; i < MEMSZ; i++)
         if (mem[i] !== ref_mem[i]) begin
            if (mism == 0) bad_at = i;
            mism++;
         end
      chk(mism == 0, req, "memory image mismatches", mism, 0);
      if (mism != 0)
         $display("FAIL %s first bad byte at %0d: got %0d expected %0d", req, bad_at,
                  mem[bad_at], ref_mem[bad_at]);
      chk(dcnt == (ok_e ? 1 : 0), "R7", "dirty region count", dcnt, ok_e ? 1 : 0);
      if (ok_e) begin
         chk(dx_g == t_dx && dy_g == t_dy, "R7", "dirty origin x*10000+y",
             dx_g * 10000 + dy_g, t_dx * 10000 + t_dy);
         chk(dw_g == t_w && dh_g == t_h, "R7", "dirty size w*10000+h",
             dw_g * 10000 + dh_g, t_w * 10000 + t_h);
         if (nb * t_h > 0)
            chk(first_wr == exp_first, "R6", "first write address", first_wr, exp_first);
      end
   endtask

   initial begin
      t_col = 32'hA1B2_C3D4;
      repeat (3) @(negedge clk);
      // R8: reset state
      chk(cmd_ready == 1'b1, "R8", "cmd_ready in reset", int'(cmd_ready), 1);
      chk(done == 1'b0 && dirty_valid == 1'b0, "R8", "done/dirty in reset", int'(done | dirty_valid), 0);
      chk(mem_wr_en == 1'b0 && mem_rd_en == 1'b0, "R8", "mem enables in reset", int'(mem_wr_en | mem_rd_en), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cmd_ready == 1'b1, "R8", "cmd_ready after reset", int'(cmd_ready), 1);

      // R4: fill sweep over pixel size and horizontal extent
      for (int b = 1; b <= 4; b++)
         for (int xi = 0; xi < 4; xi++) begin
            int xs;
            xs = (xi == 0) ? 0 : (xi == 1) ? 3 : (xi == 2) ? 7 : 15;
            set_cmd(0, 0, 0, xs, b - 1, 16 - xs, 9 - b, b, 16, 8);
            run_case("R4");
            set_cmd(0, 0, 0, xs, 7 - b, 1, 1 + b, b, 16, 8);
            run_case("R4");
         end
      t_col = 32'h1357_9BDF;
      set_cmd(0, 0, 0, 0, 0, 16, 8, 3, 16, 8);
      run_case("R4");

      // R5/R6: copies in every overlap direction
      for (int b = 1; b <= 4; b++) begin
         set_cmd(1, 1, 1, 3, 3, 8, 4, b, 16, 8); run_case("R5");
         set_cmd(1, 3, 3, 1, 1, 8, 4, b, 16, 8); run_case("R5");
         set_cmd(1, 2, 2, 5, 2, 9, 3, b, 16, 8); run_case("R5");
         set_cmd(1, 5, 2, 2, 2, 9, 3, b, 16, 8); run_case("R5");
         set_cmd(1, 0, 0, 8, 4, 8, 4, b, 16, 8); run_case("R6");
         set_cmd(1, 8, 5, 0, 0, 8, 3, b, 16, 8); run_case("R6");
         set_cmd(1, 4, 1, 4, 2, 6, 5, b, 16, 8); run_case("R6");
      end

      // R1: surface and sign checks
      set_cmd(0, 0, 0, -1, 0, 2, 2, 2, 16, 8); run_case("R1");
      set_cmd(0, 0, 0, 0, -1, 2, 2, 2, 16, 8); run_case("R1");
      set_cmd(0, 0, 0, 0, 0, -1, 2, 2, 16, 8); run_case("R1");
      set_cmd(0, 0, 0, 0, 0, 2, -1, 2, 16, 8); run_case("R1");
      set_cmd(0, 0, 0, 1, 0, 16, 2, 2, 16, 8); run_case("R1");
      set_cmd(0, 0, 0, 1, 0, 15, 2, 2, 16, 8); run_case("R1");
      set_cmd(0, 0, 0, 0, 1, 3, 8, 2, 16, 8); run_case("R1");
      set_cmd(0, 0, 0, 0, 1, 3, 7, 2, 16, 8); run_case("R1");
      set_cmd(0, 0, 0, 0, 0, 2, 2, 0, 16, 8); run_case("R1");
      set_cmd(0, 0, 0, 0, 0, 2, 2, 5, 16, 8); run_case("R1");
      // R1: hard limits on a large surface (zero area where accepted)
      set_cmd(0, 0, 0, 2368, 0, 0, 1, 1, 4000, 4000); run_case("R1");
      set_cmd(0, 0, 0, 2369, 0, 0, 1, 1, 4000, 4000); run_case("R1");
      set_cmd(0, 0, 0, 0, 0, 2368, 0, 1, 4000, 4000); run_case("R1");
      set_cmd(0, 0, 0, 0, 0, 2369, 0, 1, 4000, 4000); run_case("R1");
      set_cmd(0, 0, 0, 0, 1770, 1, 0, 1, 4000, 4000); run_case("R1");
      set_cmd(0, 0, 0, 0, 1771, 1, 0, 1, 4000, 4000); run_case("R1");
      set_cmd(0, 0, 0, 0, 0, 0, 1770, 1, 4000, 4000); run_case("R1");
      set_cmd(0, 0, 0, 0, 0, 0, 1771, 1, 4000, 4000); run_case("R1");

      // R2: copy validates both rectangles, fill ignores the source
      set_cmd(1, -1, 0, 2, 2, 4, 2, 2, 16, 8); run_case("R2");
      set_cmd(1, 0, 0, 10, 2, 8, 2, 2, 16, 8); run_case("R2");
      set_cmd(1, 0, 7, 2, 2, 4, 2, 2, 16, 8); run_case("R2");
      set_cmd(0, -5, 99, 2, 2, 4, 2, 2, 16, 8); run_case("R2");

      // R9: zero-area commands
      set_cmd(0, 0, 0, 3, 3, 0, 3, 2, 16, 8); run_case("R9");
      set_cmd(1, 1, 1, 3, 3, 4, 0, 4, 16, 8); run_case("R9");

      repeat (4) @(negedge clk);
      chk(cmd_ready == 1'b1 && done == 1'b0, "R8", "idle at end", int'(cmd_ready), 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule